// File: doc/BRIEF.md
# Four-Channel Timestamp Capture with Two-Deep Queues

The block watches four input pins and, when a chosen transition appears on one of them, records the current value of one of two free-running 16-bit counters supplied from outside. Each pin first passes through a two-flop synchronizer and a programmable glitch filter. A transition detector follows, and then a divider that can let through only every 4th or every 16th qualifying transition. Recorded values are queued per channel in a two-entry first-in-first-out store.

Software reaches the block through a small register port. It can program each channel, pull the oldest timestamp out of a channel's queue, and read or clear the status flags. A channel's interrupt line stays high while its queue holds at least one entry and the channel's interrupt enable is set. If a timestamp arrives while the queue is already full, that timestamp is discarded and a sticky overflow flag records the loss.

Register map (4-bit address, 16-bit data): address c (0 to 3) is the setup word of channel c. Address 4+c is the capture queue of channel c. Address 8 is status. Read data is combinational from the address. A read of a queue address removes the entry at the clock edge that ends the read cycle.

Top module: `edge_stamp_unit`

## Requirements
- R1: After reset every setup word reads 0, the status word reads 0 and all `irq` bits are 0.
- R2: Setup bits [1:0] choose the trigger: 00 none, 01 rising transition, 10 falling transition, 11 both transitions.
- R3: Setup bit 7 picks the stamp source (0 = `tmr_a`, 1 = `tmr_b`). The stored value is that counter's value at the clock edge N+3 edges after the first edge that samples the new pin level, where N = setup bits [6:4].
- R4: A pin level that lasts N clock periods or fewer is ignored. A level that lasts N+1 periods or more is accepted as a transition.
- R5: Setup bits [3:2] set the divider: 00 and 11 pass every qualifying transition, 01 every 4th, 10 every 16th. Writing the setup word restarts the division count.
- R6: Each queue holds two entries. Reading address 4+c returns the oldest entry and removes it, so entries leave in arrival order. Reading an empty queue returns 0 and changes nothing.
- R7: A capture that finds its queue full, with no removal in the same cycle, is dropped. It sets status bit 4+c, which stays set until software writes status with a 1 in that bit.
- R8: Status bit c is 1 exactly when queue c is not empty. `irq[c]` equals that bit ANDed with setup bit 8.
- R9: Channels are independent: activity on one pin never adds an entry to another channel's queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 4 | Asynchronous capture pins, one per channel |
| tmr_a | input | 16 | First stamp counter |
| tmr_b | input | 16 | Second stamp counter |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 16 | Register write data |
| rd_en | input | 1 | Register read strobe (removes a queue entry at queue addresses) |
| rdata | output | 16 | Register read data, combinational from `addr` |
| irq | output | 4 | Per-channel interrupt |

## Verification
Several queue properties are checked on every cycle:
- a queue changes between empty and non-empty only through a capture or a removal;
- a full queue drained with no new capture holds exactly one entry;
- the overflow flag rises only on a capture into a full queue, and falls only on a clear;
- an interrupt never asserts while its queue is empty.

Other behaviour can only be shown by the bench scenarios, because each depends on pin timing and counter values over many cycles:
- the exact stamp latency and the choice of stamp source;
- the filter's accept and reject threshold for every N;
- the divide ratios and the restart of the count on a setup write;
- the order in which queue entries come out.

// File: rtl/stamp_pkg.sv
// Shared types for the timestamp capture unit.
// Assumes the setup word fits in the low 9 bits of the register data.
package stamp_pkg;
    localparam int FLT_W = 3;   // glitch-filter length field width
    localparam int DIV_W = 4;   // division counter width (up to 16)

    // Channel setup word; field positions match the register layout.
    typedef struct packed {
        logic             ie;     // bit 8: interrupt enable
        logic             tsel;   // bit 7: stamp source select
        logic [FLT_W-1:0] flt;    // bits 6:4: filter length N
        logic [1:0]       div;    // bits 3:2: transition divider
        logic [1:0]       trig;   // bits 1:0: trigger type
    } chan_cfg_t;

    localparam int CFG_W = $bits(chan_cfg_t);
endpackage

// File: rtl/pin_qualifier.sv
// Conditions one capture pin: synchronizes it, rejects levels shorter than
// N+1 clocks, detects the selected transitions and divides them.
// Assumes the pin is low at reset; 'fire' is a one-cycle capture request.
module pin_qualifier
    import stamp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_async,
    input  logic [1:0]       trig,
    input  logic [1:0]       div,
    input  logic [FLT_W-1:0] flt,
    input  logic             restart,
    output logic             fire
);
    logic [1:0]       sync_q;
    logic             lvl_q;
    logic             lvl_d_q;
    logic [FLT_W-1:0] run_q;
    logic [DIV_W-1:0] pcnt_q;
    logic [DIV_W-1:0] lim;
    logic             rise;
    logic             fall;
    logic             qual;

    // Two-flop synchronizer for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], pin_async};
    end

    // Glitch filter: a differing level must be seen flt+1 times in a row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            run_q <= '0;
        end else if (sync_q[1] == lvl_q) begin
            run_q <= '0;
        end else if (run_q == flt) begin
            lvl_q <= sync_q[1];
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // Delayed filtered level for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d_q <= 1'b0;
        else        lvl_d_q <= lvl_q;
    end

    assign rise = lvl_q & ~lvl_d_q;
    assign fall = ~lvl_q & lvl_d_q;
    assign qual = (trig[0] & rise) | (trig[1] & fall);

    // Divider terminal count chosen by the setup field.
    always_comb begin
        case (div)
            2'b01:   lim = DIV_W'(3);
            2'b10:   lim = DIV_W'(15);
            default: lim = '0;
        endcase
    end

    // Division counter, restarted by a setup write or a disabled trigger.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || trig == 2'b00) pcnt_q <= '0;
        else if (qual)                          pcnt_q <= (pcnt_q == lim) ? '0 : pcnt_q + 1'b1;
    end

    assign fire = qual & (pcnt_q == lim) & ~restart;
endmodule

// File: rtl/stamp_queue.sv
// Small FIFO for captured stamps with a sticky overflow flag.
// A push into a full queue succeeds only when a pop happens in the same
// cycle; otherwise the new value is dropped and 'ovf' is set.
module stamp_queue #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         ovf_clr,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] rp_q;
    logic [PW-1:0] wp_q;
    logic [CW-1:0] cnt_q;
    logic          pop_ok;
    logic          push_ok;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign pop_ok  = pop & ~empty;
    assign push_ok = push & (~full | pop_ok);
    assign dout    = empty ? '0 : mem_q[rp_q];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem_q[wp_q] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_q  <= '0;
            wp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wp_q <= step(wp_q);
            if (pop_ok)  rp_q <= step(rp_q);
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // Sticky overflow; a new loss wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)               ovf <= 1'b0;
        else if (push & ~push_ok) ovf <= 1'b1;
        else if (ovf_clr)         ovf <= 1'b0;
    end
endmodule

// File: rtl/edge_stamp_unit.sv
// Four-channel timestamp capture. Each channel qualifies its pin, stamps
// one of two external counters and queues the stamp. A register port gives
// setup, queue removal and status. Map: c = setup, NCH+c = queue,
// 2*NCH = status {overflow[NCH], not_empty[NCH]}.
// Assumes TW >= CFG_W and TW >= 2*NCH.
module edge_stamp_unit
    import stamp_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int TW    = 16,
    parameter int DEPTH = 2,
    parameter int AW    = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pin_in,
    input  logic [TW-1:0]  tmr_a,
    input  logic [TW-1:0]  tmr_b,
    input  logic [AW-1:0]  addr,
    input  logic           wr_en,
    input  logic [TW-1:0]  wdata,
    input  logic           rd_en,
    output logic [TW-1:0]  rdata,
    output logic [NCH-1:0] irq
);
    localparam logic [AW-1:0] STAT_A = AW'(2 * NCH);

    chan_cfg_t      cfg_q [NCH];
    logic [TW-1:0]  dout_v [NCH];
    logic [NCH-1:0] fire_v;
    logic [NCH-1:0] empty_v;
    logic [NCH-1:0] full_v;
    logic [NCH-1:0] ovf_v;
    logic [NCH-1:0] pop_v;
    logic [NCH-1:0] cfg_wr_v;
    logic [NCH-1:0] ovf_clr_v;
    logic           unused_wbits;

    assign unused_wbits = ^wdata[TW-1:CFG_W];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign cfg_wr_v[g]  = wr_en & (addr == AW'(g));
        assign pop_v[g]     = rd_en & (addr == AW'(NCH + g));
        assign ovf_clr_v[g] = wr_en & (addr == STAT_A) & wdata[NCH + g];

        // Setup register of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)          cfg_q[g] <= '0;
            else if (cfg_wr_v[g]) cfg_q[g] <= chan_cfg_t'(wdata[CFG_W-1:0]);
        end

        pin_qualifier i_qual (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (pin_in[g]),
            .trig      (cfg_q[g].trig),
            .div       (cfg_q[g].div),
            .flt       (cfg_q[g].flt),
            .restart   (cfg_wr_v[g]),
            .fire      (fire_v[g])
        );

        stamp_queue #(.W(TW), .DEPTH(DEPTH)) i_queue (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (fire_v[g]),
            .din     (cfg_q[g].tsel ? tmr_b : tmr_a),
            .pop     (pop_v[g]),
            .ovf_clr (ovf_clr_v[g]),
            .dout    (dout_v[g]),
            .empty   (empty_v[g]),
            .full    (full_v[g]),
            .ovf     (ovf_v[g])
        );

        assign irq[g] = ~empty_v[g] & cfg_q[g].ie;
    end

    // Combinational read mux over setup, queue heads and status.
    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (addr == AW'(c))       rdata = TW'(cfg_q[c]);
            if (addr == AW'(NCH + c)) rdata = dout_v[c];
        end
        if (addr == STAT_A) rdata = TW'({ovf_v, ~empty_v});
    end
endmodule

// File: rtl/edge_stamp_chk.sv
// Cycle-by-cycle properties of the capture queues, bound into the top.
module edge_stamp_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] fire_v,
    input logic [NCH-1:0] empty_v,
    input logic [NCH-1:0] full_v,
    input logic [NCH-1:0] ovf_v,
    input logic [NCH-1:0] pop_v,
    input logic [NCH-1:0] ovf_clr_v,
    input logic [NCH-1:0] irq
);
    for (genvar c = 0; c < NCH; c++) begin : g_prop
        assert_keep_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
            empty_v[c] && !fire_v[c] |=> empty_v[c]);
        assert_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
            empty_v[c] && fire_v[c] |=> !empty_v[c]);
        assert_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
            full_v[c] && pop_v[c] && !fire_v[c] |=> !full_v[c] && !empty_v[c]);
        assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_v[c] && !ovf_clr_v[c] |=> ovf_v[c]);
        assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !ovf_v[c] && !(full_v[c] && fire_v[c] && !pop_v[c]) |=> !ovf_v[c]);
        assert_irq_ne_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq[c] |-> !empty_v[c]);
    end
endmodule

bind edge_stamp_unit edge_stamp_chk #(.NCH(NCH)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_v    (fire_v),
    .empty_v   (empty_v),
    .full_v    (full_v),
    .ovf_v     (ovf_v),
    .pop_v     (pop_v),
    .ovf_clr_v (ovf_clr_v),
    .irq       (irq)
);

// File: tb/test_edge_stamp_unit.sv
// Bench: sweeps channels, triggers, sources and filter lengths, then
// divider, filter-threshold, overflow and independence scenarios.
module test_edge_stamp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pin_in = '0;
    logic [15:0] tmr_a = 16'h1000;
    logic [15:0] tmr_b = 16'h8000;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rdata;
    logic [3:0]  irq;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    edge_stamp_unit i_edge_stamp_unit (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tmr_a(tmr_a), .tmr_b(tmr_b),
        .addr(addr), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
        .rdata(rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // Stamp counters advance on the falling edge, away from sampling.
    always @(negedge clk) begin
        tmr_a <= tmr_a + 16'd1;
        tmr_b <= tmr_b + 16'd3;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic set_pin(input int ch, input logic v, output logic [15:0] ta, output logic [15:0] tb);
        @(negedge clk); #1;
        pin_in[ch] = v; ta = tmr_a; tb = tmr_b;
    endtask

    // Pulse of w clock periods; returns counters at rise.
    task automatic pulse(input int ch, input int w, output logic [15:0] ta, output logic [15:0] tb);
        logic [15:0] xa, xb;
        set_pin(ch, 1'b1, ta, tb);
        repeat (w - 1) @(negedge clk);
        set_pin(ch, 1'b0, xa, xb);
    endtask

    function automatic logic [15:0] stamp(input logic sel, input logic [15:0] ta,
                                          input logic [15:0] tb, input int n);
        return sel ? 16'(tb + 16'(3 * (3 + n))) : 16'(ta + 16'(3 + n));
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] d, ra, rb, fa, fb;
        logic [15:0] ea [4];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int c = 0; c < 4; c++) begin
            rd(4'(c), d); chk(d == 0, "R1 setup reset", d, 0);
        end
        rd(4'd8, d); chk(d == 0, "R1 status reset", d, 0);
        chk(irq == 0, "R1 irq reset", irq, 0);

        // R2 R3 R8: sweep channel x trigger x source x filter length
        for (int ch = 0; ch < 4; ch++) begin
            for (int m = 1; m < 4; m++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int n = 0; n < 8; n++) begin
                        int k;
                        logic [15:0] cw;
                        cw = 16'((s << 8) | (s << 7) | (n << 4) | m);
                        wr(4'(ch), cw);
                        set_pin(ch, 1'b1, ra, rb);
                        repeat (n + 3) @(negedge clk);
                        set_pin(ch, 1'b0, fa, fb);
                        repeat (n + 12) @(negedge clk);
                        k = 0;
                        if (m[0]) begin ea[k] = stamp(s[0], ra, rb, n); k++; end
                        if (m[1]) begin ea[k] = stamp(s[0], fa, fb, n); k++; end
                        #1 chk(irq[ch] == s[0], "R8 irq with entries", irq[ch], s);
                        rd(4'd8, d);
                        chk(d[ch] == 1'b1, "R8 not-empty bit", d[ch], 1);
                        for (int i = 0; i < k; i++) begin
                            rd(4'(4 + ch), d);
                            chk(d == ea[i], "R3 stamp value", d, ea[i]);
                        end
                        rd(4'(4 + ch), d);
                        chk(d == 0, "R2 no extra capture", d, 0);
                        rd(4'd8, d);
                        chk(d == 0, "R6 queue drained", d, 0);
                        rd(4'(ch), d);
                        chk(d == cw, "R2 setup readback", d, cw);
                    end
                end
            end
            wr(4'(ch), 16'h0);
        end

        // R2: trigger 00 captures nothing
        wr(4'd1, 16'h0070);
        pulse(1, 10, ra, rb); repeat (20) @(negedge clk);
        rd(4'd8, d); chk(d == 0, "R2 trigger off", d, 0);

        // R4: filter threshold at N=5 and N=0
        wr(4'd0, 16'h0051);
        pulse(0, 5, ra, rb); repeat (20) @(negedge clk);
        rd(4'd8, d); chk(d == 0, "R4 short level rejected", d, 0);
        pulse(0, 6, ra, rb); repeat (20) @(negedge clk);
        rd(4'd4, d); chk(d == stamp(1'b0, ra, rb, 5), "R4 N+1 level accepted", d, stamp(1'b0, ra, rb, 5));
        wr(4'd0, 16'h0001);
        pulse(0, 1, ra, rb); repeat (12) @(negedge clk);
        rd(4'd4, d); chk(d == stamp(1'b0, ra, rb, 0), "R4 single-cycle at N=0", d, stamp(1'b0, ra, rb, 0));

        // R5: divide by 4 over eight pulses
        wr(4'd2, 16'h0005);
        for (int p = 1; p <= 8; p++) begin
            pulse(2, 3, ra, rb); repeat (8) @(negedge clk);
            if (p == 4) ea[0] = stamp(1'b0, ra, rb, 0);
            if (p == 8) ea[1] = stamp(1'b0, ra, rb, 0);
            if (p == 3) begin
                rd(4'd8, d); chk(d == 0, "R5 no capture before 4th", d, 0);
            end
        end
        rd(4'd6, d); chk(d == ea[0], "R5 4th transition", d, ea[0]);
        rd(4'd6, d); chk(d == ea[1], "R5 8th transition", d, ea[1]);
        // R5: setup write restarts the count
        wr(4'd2, 16'h0005);
        pulse(2, 3, ra, rb); repeat (8) @(negedge clk);
        pulse(2, 3, ra, rb); repeat (8) @(negedge clk);
        wr(4'd2, 16'h0005);
        for (int p = 1; p <= 4; p++) begin
            pulse(2, 3, ra, rb); repeat (8) @(negedge clk);
            if (p == 3) begin
                rd(4'd8, d); chk(d == 0, "R5 restart after write", d, 0);
            end
        end
        rd(4'd6, d); chk(d == stamp(1'b0, ra, rb, 0), "R5 capture after restart", d, stamp(1'b0, ra, rb, 0));
        // R5: divide by 16
        wr(4'd2, 16'h0009);
        for (int p = 1; p <= 16; p++) begin
            pulse(2, 3, ra, rb); repeat (8) @(negedge clk);
            if (p == 15) begin
                rd(4'd8, d); chk(d == 0, "R5 none before 16th", d, 0);
            end
        end
        rd(4'd6, d); chk(d == stamp(1'b0, ra, rb, 0), "R5 16th transition", d, stamp(1'b0, ra, rb, 0));
        // R5: code 11 passes every transition
        wr(4'd2, 16'h000D);
        pulse(2, 3, ra, rb); repeat (8) @(negedge clk);
        rd(4'd6, d); chk(d == stamp(1'b0, ra, rb, 0), "R5 code 11 every edge", d, stamp(1'b0, ra, rb, 0));

        // R7: third capture into full queue is dropped, flag sticky
        wr(4'd3, 16'h0181);
        for (int p = 0; p < 3; p++) begin
            pulse(3, 3, ra, rb); repeat (8) @(negedge clk);
            if (p < 2) ea[p] = stamp(1'b1, ra, rb, 0);
        end
        rd(4'd8, d); chk(d == 16'h0088, "R7 overflow and not-empty", d, 16'h0088);
        chk(irq == 4'b1000, "R8 irq on channel 3 only", irq, 4'b1000);
        rd(4'd7, d); chk(d == ea[0], "R6 oldest first", d, ea[0]);
        rd(4'd7, d); chk(d == ea[1], "R7 newest dropped", d, ea[1]);
        rd(4'd8, d); chk(d == 16'h0080, "R7 flag survives reads", d, 16'h0080);
        wr(4'd8, 16'h0070);
        rd(4'd8, d); chk(d == 16'h0080, "R7 clear other bits ignored", d, 16'h0080);
        wr(4'd8, 16'h0080);
        rd(4'd8, d); chk(d == 0, "R7 flag cleared", d, 0);

        // R9: two channels at once, others stay empty
        wr(4'd0, 16'h0001);
        wr(4'd2, 16'h0082);
        wr(4'd1, 16'h0000);
        wr(4'd3, 16'h0000);
        @(negedge clk); #1;
        pin_in = 4'b1111; ra = tmr_a; rb = tmr_b;
        repeat (4) @(negedge clk);
        #1 pin_in = 4'b0000; fa = tmr_a; fb = tmr_b;
        repeat (12) @(negedge clk);
        rd(4'd8, d); chk(d == 16'h0005, "R9 only channels 0 and 2", d, 16'h0005);
        rd(4'd4, d); chk(d == stamp(1'b0, ra, rb, 0), "R9 channel 0 stamp", d, stamp(1'b0, ra, rb, 0));
        rd(4'd6, d); chk(d == stamp(1'b1, fa, fb, 0), "R9 channel 2 stamp", d, stamp(1'b1, fa, fb, 0));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule